// File: doc/BRIEF.md
# Show-Ahead FIFO on Registered-Read Memory

This block is a single-clock first-in first-out queue whose entries live in a two-port memory with one write port and one read port, where the read data only appears one clock after the address is presented. Such memories are the only kind some programmable fabrics offer, yet consumers of a FIFO usually want the oldest word already sitting on the output before they ask for it. The block closes that gap, so the head word is valid at `data_out` in every cycle in which `empty` is low.

Two mechanisms hide the read latency. First, the memory is addressed every cycle with the read pointer the queue will have after the current clock edge, so the word that becomes the head is already in the memory's output register when it is needed. Second, a word that enters a queue that is empty, or that is about to become empty through a pop in the same cycle, cannot come back out of memory in time. That word is also copied into a bypass register, and the output is taken from it for exactly one cycle. A synchronous flush discards all contents at once.

Top module: `sram_show_ahead_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `usage` is 0.
- R2: Whenever `empty` is 0, `data_out` equals the oldest stored word. After a pop, the next older word is on `data_out` in the following cycle.
- R3: A word pushed into an empty FIFO is on `data_out`, with `empty` at 0, in the very next cycle. A pop in that cycle removes exactly that word.
- R4: With the FIFO non-empty and a push and a pop in every cycle, words leave in push order, one per cycle, with no stall cycle.
- R5: A push and a pop in the same cycle on a one-entry FIFO leave `usage` at 1 and put the pushed word on `data_out` in the next cycle.
- R6: `usage` equals the number of stored words. It never exceeds DEPTH. `full` is 1 exactly when `usage` equals DEPTH, and `empty` is 1 exactly when `usage` is 0.
- R7: A push while `full` is 1 is ignored. Without a pop, `usage` and `data_out` are unchanged. With a pop, only the pop takes effect and `usage` drops by one.
- R8: A pop while `empty` is 1 is ignored. The FIFO stays empty, and a later push behaves as into a freshly reset FIFO.
- R9: When `flush` is 1, then in the next cycle `empty` is 1 and `usage` is 0. A push or pop in the flush cycle is ignored, and no word stored before the flush is ever output.
- R10: Order and contents are preserved across pointer wrap-around, when more than DEPTH words pass through the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous discard of all contents |
| push | input | 1 | Write request for `data_in` |
| data_in | input | WIDTH | Word to store |
| full | output | 1 | FIFO holds DEPTH words |
| pop | input | 1 | Remove the head word |
| data_out | output | WIDTH | Head word, valid while `empty` is 0 |
| empty | output | 1 | FIFO holds no words |
| usage | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The two functions that share a cycle are a write into memory and the read-ahead of the same entry. This happens when a push meets an empty FIFO, or meets a one-entry FIFO together with a pop. The bench provokes the case with a directed push followed at once by a pop, a push-and-pop on a single entry, and full-rate streaming, and random traffic with shifting push and pop biases hits it repeatedly. Each cycle, the bench compares `data_out`, `usage`, `full` and `empty` against a queue model that knows nothing about the bypass path, so a stale memory word shows up as a data mismatch.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    // Source of the head word presented at the output
    typedef enum logic {
        SRC_RAM = 1'b0,
        SRC_BYP = 1'b1
    } head_src_e;
endpackage

// File: rtl/fifo_sync_ram.sv
// Two-port memory: one write port, one read port with one-cycle registered read.
module fifo_sync_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/fifo_ptr_ctrl.sv
// Pointers, occupancy and read-ahead address generation.
module fifo_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [AW-1:0] ram_raddr,
    output logic          load_byp,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] usage
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign usage = st_q.cnt;

    always_comb begin
        st_d      = st_q;
        do_push   = push && !full;
        do_pop    = pop && !empty;
        ram_we    = 1'b0;
        ram_waddr = st_q.wr_ptr;
        ram_raddr = st_q.rd_ptr;
        load_byp  = 1'b0;
        if (flush) begin
            st_d = '0;
        end else begin
            ram_we = do_push;
            if (do_push) begin
                st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            end
            if (do_pop) begin
                st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            end
            // read ahead: address the entry that will be head after this edge
            ram_raddr = st_d.rd_ptr;
            // that entry is written in this very cycle: memory cannot return it
            load_byp = do_push &&
                       ((st_q.cnt == '0) || ((st_q.cnt == CW'(1)) && do_pop));
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R7
    full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !flush |=> full && $stable(usage));
    // R8
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push && !flush |=> empty);
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && (usage == '0));
    // R4
    stream_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !empty && !full && !flush |=> $stable(usage));
endmodule

// File: rtl/fifo_head_bypass.sv
// Bypass register for a word that memory cannot return in time, plus output select.
module fifo_head_bypass
    import fifo_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load_byp,
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic [WIDTH-1:0] head
);
    typedef struct packed {
        logic [WIDTH-1:0] byp;
        head_src_e        src;
    } byp_t;

    byp_t bs_d, bs_q;

    always_comb begin
        bs_d     = bs_q;
        bs_d.src = SRC_RAM;
        if (!flush && load_byp) begin
            bs_d.byp = data_in;
            bs_d.src = SRC_BYP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '{byp: '0, src: SRC_RAM};
        end else begin
            bs_q <= bs_d;
        end
    end

    assign head = (bs_q.src == SRC_BYP) ? bs_q.byp : ram_rdata;

    // R3
    byp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_q.src == SRC_BYP) && !load_byp |=> bs_q.src == SRC_RAM);
endmodule

// File: rtl/sram_show_ahead_fifo.sv
module sram_show_ahead_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] data_in,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] data_out,
    output logic             empty,
    output logic [CW-1:0]    usage
);
    logic             ram_we;
    logic [AW-1:0]    ram_waddr, ram_raddr;
    logic [WIDTH-1:0] ram_rdata;
    logic             load_byp;

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk, .rst_n, .flush, .push, .pop,
        .ram_we, .ram_waddr, .ram_raddr, .load_byp,
        .full, .empty, .usage
    );

    fifo_sync_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk, .we(ram_we), .waddr(ram_waddr), .wdata(data_in),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    fifo_head_bypass #(.WIDTH(WIDTH)) u_byp (
        .clk, .rst_n, .flush, .load_byp, .data_in, .ram_rdata,
        .head(data_out)
    );

    // R3
    first_word_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && empty && !flush |=> !empty && (data_out == $past(data_in)));
    // R5
    single_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && (usage == CW'(1)) && !flush |=>
            (usage == CW'(1)) && (data_out == $past(data_in)));
endmodule

// File: tb/tb_sram_show_ahead_fifo.sv
`timescale 1ns/1ps
module tb_sram_show_ahead_fifo;
    localparam int WIDTH = 16;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0, push = 1'b0, pop = 1'b0;
    logic [WIDTH-1:0] data_in = '0;
    logic             full, empty;
    logic [WIDTH-1:0] data_out;
    logic [CW-1:0]    usage;

    int n_chk = 0;
    int n_fail = 0;
    logic [WIDTH-1:0] model_q [$];
    logic [WIDTH-1:0] next_word = 16'h1000;

    always #2 clk = ~clk;

    sram_show_ahead_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .clk, .rst_n, .flush, .push, .data_in, .full, .pop,
        .data_out, .empty, .usage
    );

    function automatic logic exp_empty();
        return model_q.size() == 0;
    endfunction

    function automatic logic exp_full();
        return model_q.size() == DEPTH;
    endfunction

    task automatic check_state(input string tag);
        n_chk++;
        if (usage != CW'(model_q.size())) begin
            n_fail++;
            $display("FAIL %s usage: actual=%0d expected=%0d", tag, usage, model_q.size());
        end
        if (empty != exp_empty() || full != exp_full()) begin
            n_fail++;
            $display("FAIL %s flags: actual empty=%0b full=%0b expected empty=%0b full=%0b",
                     tag, empty, full, exp_empty(), exp_full());
        end
        if (model_q.size() > 0 && data_out !== model_q[0]) begin
            n_fail++;
            $display("FAIL %s data_out: actual=%h expected=%h", tag, data_out, model_q[0]);
        end
    endtask

    // check the present state, then drive one cycle and advance the model
    task automatic step(input logic f, input logic p, input logic q, input string tag);
        int sz;
        @(negedge clk);
        check_state(tag);
        flush   = f;
        push    = p;
        pop     = q;
        data_in = next_word;
        sz = model_q.size();
        if (f) begin
            model_q.delete();
        end else begin
            if (q && sz > 0) void'(model_q.pop_front());
            if (p && sz < DEPTH) model_q.push_back(next_word);
        end
        if (p) next_word = next_word + 16'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, "R1");
        // R3 push into empty, pop right after
        step(0, 1, 0, "R1");
        step(0, 0, 1, "R3");
        step(0, 0, 0, "R3");
        // R8 pop while empty ignored, then push behaves normally
        step(0, 0, 1, "R8");
        step(0, 1, 0, "R8");
        // R5 push and pop on one entry
        step(0, 1, 1, "R8");
        step(0, 0, 0, "R5");
        // R6 fill to full
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R6");
        // R7 push while full ignored, then push with pop
        step(0, 1, 0, "R6");
        step(0, 1, 1, "R7");
        step(0, 0, 0, "R7");
        // R2 drain
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, "R2");
        // R4 streaming at full rate
        step(0, 1, 0, "R2");
        step(0, 1, 0, "R4");
        for (int i = 0; i < 40; i++) step(0, 1, 1, "R4");
        // R9 flush with a push and a pop in the same cycle
        step(1, 1, 1, "R4");
        step(0, 0, 0, "R9");
        step(0, 1, 0, "R9");
        step(0, 0, 0, "R9");
        step(1, 0, 0, "R9");
        // R10 random traffic with varying bias
        for (int blk = 0; blk < 30; blk++) begin
            int pp = 20 + int'($urandom_range(0, 60));
            for (int i = 0; i < 100; i++) begin
                logic p = ($urandom_range(0, 99) < pp);
                logic q = ($urandom_range(0, 99) >= pp - 10);
                logic f = ($urandom_range(0, 299) == 0);
                step(f, p, q, "R10");
            end
        end
        step(0, 0, 0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule